// File: doc/BRIEF.md
# Issue Window Wakeup and Select

This block holds a small window of waiting instructions for an out-of-order core. Each occupied slot keeps two source operand tags, a ready flag per operand and the destination tag the instruction will produce. Every cycle a number of result tags arrive on broadcast lanes. Each slot compares both of its source tags against every valid lane, and a hit on any lane sets that operand's ready flag. A slot whose two operands are ready asks to issue.

Selection uses a binary tree of arbiter cells. Requests are ORed upward, and an enable travels back down the tree. At every cell the enable favours the lower-indexed half, so the grant lands on exactly one requesting slot. The tree depth is the base-2 logarithm of the window size. One tree per functional unit is placed in series. Each later tree sees only the requests that the earlier trees left ungranted. Granted slots are freed at the next clock edge. A simple insert port writes a new instruction into the lowest free slot. It takes the operand ready flags from an outside ready table, and it also catches a matching broadcast in the insert cycle.

Top module: `issue_window`

## Requirements
- R1: After a synchronous active-low reset, no slot is occupied, no grant is raised (`gnt_valid` all zero) and `ins_ready` is 1.
- R2: `ins_ready` is 1 exactly when at least one slot is free. An insert with `ins_valid` high goes to the lowest-numbered free slot. An insert while the window is full is ignored and leaves every slot unchanged.
- R3: The ready flags of an inserted slot are `ins_rdy_l` / `ins_rdy_r`, each also set when its source tag equals a valid broadcast lane in the insert cycle. A slot inserted with both flags set can be granted in the very next cycle.
- R4: A held slot whose source tag equals the tag on any lane k with `bc_valid[k]` = 1 has that operand ready from the next cycle on. Lane k is `bc_tag[k*TAG_W +: TAG_W]`. A lane with `bc_valid[k]` = 0 has no effect.
- R5: A slot requests issue only when it is occupied and both operand flags are set. A grant is given only to a requesting slot.
- R6: In each cycle, unit f (`gnt_valid[f]`, `gnt_idx[f*IDX_W +: IDX_W]`, `gnt_dst[f*TAG_W +: TAG_W]`) is granted the requesting slot with exactly f requesting slots of lower index. Unit f raises no grant when fewer than f+1 slots request. The grant outputs follow the slot state in the same cycle.
- R7: A granted slot is free from the next clock edge and is never granted twice.
- R8: A granted destination tag broadcast in its grant cycle wakes a waiting dependent slot, and that slot can be granted in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ins_valid | input | 1 | Insert request |
| ins_src_l | input | TAG_W | Left source tag of the new instruction |
| ins_src_r | input | TAG_W | Right source tag of the new instruction |
| ins_dst | input | TAG_W | Destination tag of the new instruction |
| ins_rdy_l | input | 1 | Left operand ready, from the ready table |
| ins_rdy_r | input | 1 | Right operand ready, from the ready table |
| ins_ready | output | 1 | A free slot exists |
| bc_valid | input | IW | Per-lane broadcast valid |
| bc_tag | input | IW*TAG_W | Broadcast result tags, lane k at bits k*TAG_W |
| gnt_valid | output | NFU | Per-unit grant valid |
| gnt_idx | output | NFU*IDX_W | Granted slot index per unit |
| gnt_dst | output | NFU*TAG_W | Destination tag of the granted slot per unit |

## Verification
Directed sequences cover four cases. One wakes a slot one operand at a time, with a disabled lane carrying a matching tag, to show that a half-ready slot never requests. Another inserts with a same-cycle matching broadcast, which tells the insert-time match apart from the ready-table input. A dependent chain is woken by the broadcast of a granted tag in its grant cycle. A full window is filled, then a ready insert is attempted and a mass wakeup drains two slots per cycle in index order. A random phase with a small tag space makes multi-lane hits and collisions frequent. In that phase the broadcast of granted tags mixes with random tags, so priority, slot reuse and the order of insert and free are compared against the reference model on every cycle.

// File: rtl/iw_pkg.sv
// Shared types for the issue window.
// Assumes nothing beyond a standard synthesizable flow.
package iw_pkg;

    // Per-slot status flags held in the window.
    typedef struct packed {
        logic occ;    // slot holds an instruction
        logic rdy_l;  // left operand available
        logic rdy_r;  // right operand available
    } slot_flags_t;

endpackage

// File: rtl/iw_tag_match.sv
// Compares one source tag against every broadcast lane and reports a hit
// if any lane with its valid bit set carries the same tag.
// Assumes lane k occupies bits [k*TAG_W +: TAG_W] of bc_tag.
module iw_tag_match #(
    parameter int IW    = 2,
    parameter int TAG_W = 6
) (
    input  logic [TAG_W-1:0]    tag,
    input  logic [IW-1:0]       bc_valid,
    input  logic [IW*TAG_W-1:0] bc_tag,
    output logic                hit
);

    // OR of the per-lane equality matches.
    always_comb begin
        hit = 1'b0;
        for (int k = 0; k < IW; k++) begin
            if (bc_valid[k] && (bc_tag[k*TAG_W +: TAG_W] == tag)) begin
                hit = 1'b1;
            end
        end
    end

endmodule

// File: rtl/iw_arb_tree.sv
// Binary arbiter tree. Requests are ORed toward the root, and the enable is
// passed back down. Each cell prefers its lower-indexed child. With en high
// and any request present, exactly one request bit is granted.
// Assumes N is a power of two and at least 2. Node n has children 2n and 2n+1,
// and the leaves are nodes N..2N-1.
module iw_arb_tree #(
    parameter int N = 8
) (
    input  logic         en,
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt,
    output logic         any_req
);

    localparam int NODES = 2 * N;

    logic [NODES-1:1] up;
    logic [NODES-1:1] dn;

    assign dn[1]   = en;
    assign any_req = up[1];

    genvar g;
    generate
        // Leaves: request in, grant out.
        for (g = 0; g < N; g++) begin : g_leaf
            assign up[N+g] = req[g];
            assign gnt[g]  = dn[N+g];
        end
        // Inner cells: combine the requests, steer the enable to the lower child first.
        for (g = 1; g < N; g++) begin : g_cell
            assign up[g]       = up[2*g] | up[2*g+1];
            assign dn[2*g]     = dn[g] & up[2*g];
            assign dn[2*g+1]   = dn[g] & up[2*g+1] & ~up[2*g];
        end
    endgenerate

endmodule

// File: rtl/issue_window.sv
// Issue window with tag-broadcast wakeup and tree selection for NFU units.
// Slots wake on matches against IW broadcast lanes. Ready slots request issue,
// and arbiter trees in series grant one slot per unit, lowest index first.
// Granted slots are freed at the next edge. The insert port fills the
// lowest free slot.
// Assumes WINSIZE is a power of two, at least 2, and NFU <= WINSIZE.
module issue_window
    import iw_pkg::*;
#(
    parameter int WINSIZE = 8,
    parameter int IW      = 2,
    parameter int NFU     = 2,
    parameter int TAG_W   = 6,
    localparam int IDX_W  = $clog2(WINSIZE)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ins_valid,
    input  logic [TAG_W-1:0]     ins_src_l,
    input  logic [TAG_W-1:0]     ins_src_r,
    input  logic [TAG_W-1:0]     ins_dst,
    input  logic                 ins_rdy_l,
    input  logic                 ins_rdy_r,
    output logic                 ins_ready,
    input  logic [IW-1:0]        bc_valid,
    input  logic [IW*TAG_W-1:0]  bc_tag,
    output logic [NFU-1:0]       gnt_valid,
    output logic [NFU*IDX_W-1:0] gnt_idx,
    output logic [NFU*TAG_W-1:0] gnt_dst
);

    slot_flags_t      flags_q [WINSIZE];
    logic [TAG_W-1:0] tagl_q  [WINSIZE];
    logic [TAG_W-1:0] tagr_q  [WINSIZE];
    logic [TAG_W-1:0] dst_q   [WINSIZE];

    logic [WINSIZE-1:0] slot_valid;
    logic [WINSIZE-1:0] slot_req;
    logic [WINSIZE-1:0] hit_l;
    logic [WINSIZE-1:0] hit_r;
    logic [WINSIZE-1:0] free_oh;
    logic [WINSIZE-1:0] grant_all;
    logic [WINSIZE-1:0] stage_req [NFU+1];
    logic [WINSIZE-1:0] gnt_oh    [NFU];
    logic               ins_hit_l;
    logic               ins_hit_r;
    logic               ins_fire;

    genvar gi;
    generate
        // Per-slot wakeup comparators and request formation.
        for (gi = 0; gi < WINSIZE; gi++) begin : g_slot
            iw_tag_match #(.IW(IW), .TAG_W(TAG_W)) i_match_l (
                .tag(tagl_q[gi]), .bc_valid(bc_valid), .bc_tag(bc_tag), .hit(hit_l[gi])
            );
            iw_tag_match #(.IW(IW), .TAG_W(TAG_W)) i_match_r (
                .tag(tagr_q[gi]), .bc_valid(bc_valid), .bc_tag(bc_tag), .hit(hit_r[gi])
            );
            assign slot_valid[gi] = flags_q[gi].occ;
            assign slot_req[gi]   = flags_q[gi].occ & flags_q[gi].rdy_l & flags_q[gi].rdy_r;
        end

        // Select stages in series: each unit sees what earlier units left.
        assign stage_req[0] = slot_req;
        for (gi = 0; gi < NFU; gi++) begin : g_fu
            iw_arb_tree #(.N(WINSIZE)) i_sel (
                .en(1'b1), .req(stage_req[gi]), .gnt(gnt_oh[gi]), .any_req(gnt_valid[gi])
            );
            assign stage_req[gi+1] = stage_req[gi] & ~gnt_oh[gi];
        end
    endgenerate

    // Insert-time wakeup against the broadcasts of the same cycle.
    iw_tag_match #(.IW(IW), .TAG_W(TAG_W)) i_ins_match_l (
        .tag(ins_src_l), .bc_valid(bc_valid), .bc_tag(bc_tag), .hit(ins_hit_l)
    );
    iw_tag_match #(.IW(IW), .TAG_W(TAG_W)) i_ins_match_r (
        .tag(ins_src_r), .bc_valid(bc_valid), .bc_tag(bc_tag), .hit(ins_hit_r)
    );

    // Free-slot finder reuses the arbiter tree on the empty slots.
    iw_arb_tree #(.N(WINSIZE)) i_free (
        .en(1'b1), .req(~slot_valid), .gnt(free_oh), .any_req(ins_ready)
    );

    assign ins_fire = ins_valid & ins_ready;

    // Collect all grants and encode the per-unit index and destination.
    always_comb begin
        grant_all = '0;
        gnt_idx   = '0;
        gnt_dst   = '0;
        for (int f = 0; f < NFU; f++) begin
            grant_all = grant_all | gnt_oh[f];
            for (int i = 0; i < WINSIZE; i++) begin
                if (gnt_oh[f][i]) begin
                    gnt_idx[f*IDX_W +: IDX_W] = IDX_W'(i);
                    gnt_dst[f*TAG_W +: TAG_W] = dst_q[i];
                end
            end
        end
    end

    // Slot state: free on grant, load on insert, otherwise accumulate wakeups.
    always_ff @(posedge clk) begin
        for (int i = 0; i < WINSIZE; i++) begin
            if (!rst_n) begin
                flags_q[i] <= '0;
                tagl_q[i]  <= '0;
                tagr_q[i]  <= '0;
                dst_q[i]   <= '0;
            end else if (grant_all[i]) begin
                flags_q[i].occ <= 1'b0;
            end else if (ins_fire && free_oh[i]) begin
                flags_q[i].occ   <= 1'b1;
                flags_q[i].rdy_l <= ins_rdy_l | ins_hit_l;
                flags_q[i].rdy_r <= ins_rdy_r | ins_hit_r;
                tagl_q[i]        <= ins_src_l;
                tagr_q[i]        <= ins_src_r;
                dst_q[i]         <= ins_dst;
            end else if (flags_q[i].occ) begin
                flags_q[i].rdy_l <= flags_q[i].rdy_l | hit_l[i];
                flags_q[i].rdy_r <= flags_q[i].rdy_r | hit_r[i];
            end
        end
    end

endmodule

// File: rtl/iw_checker.sv
// Property checker for issue_window, attached with bind.
// Observes slot occupancy, requests and grants.
module iw_checker #(
    parameter int WINSIZE = 8,
    parameter int NFU     = 2,
    localparam int IDX_W  = $clog2(WINSIZE)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [WINSIZE-1:0]   slot_valid,
    input logic [WINSIZE-1:0]   slot_req,
    input logic [WINSIZE-1:0]   grant_all,
    input logic [NFU-1:0]       gnt_valid,
    input logic [NFU*IDX_W-1:0] gnt_idx,
    input logic                 ins_ready
);

    // R2
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ins_ready |=> ($countones(slot_valid) <= $past($countones(slot_valid))));

    // R5
    grant_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_all & ~slot_req) == '0);

    // R6
    one_slot_per_unit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(grant_all) == $countones(gnt_valid));

    genvar gf, gs;
    generate
        for (gf = 0; gf < NFU; gf++) begin : g_unit
            // R6
            rank_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
                gnt_valid[gf] |-> ($countones(slot_req &
                    ((WINSIZE'(1) << gnt_idx[gf*IDX_W +: IDX_W]) - WINSIZE'(1))) == gf));
        end
        for (gs = 0; gs < WINSIZE; gs++) begin : g_slot
            // R7
            freed_after_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
                grant_all[gs] |=> !slot_valid[gs]);
            // R5
            req_only_occupied_chk: assert property (@(posedge clk) disable iff (!rst_n)
                slot_req[gs] |-> slot_valid[gs]);
        end
    endgenerate

endmodule

bind issue_window iw_checker #(.WINSIZE(WINSIZE), .NFU(NFU)) i_iw_checker (
    .clk(clk), .rst_n(rst_n), .slot_valid(slot_valid), .slot_req(slot_req),
    .grant_all(grant_all), .gnt_valid(gnt_valid), .gnt_idx(gnt_idx), .ins_ready(ins_ready)
);

// File: tb/test_issue_window.sv
// Bench for issue_window: directed scenarios plus a random phase, with a
// behavioural reference model compared on every clock.
module test_issue_window;

    localparam int CLK_PERIOD = 10;
    localparam int WIN   = 8;
    localparam int LANES = 2;
    localparam int UNITS = 2;
    localparam int TW    = 6;
    localparam int XW    = 3;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  ins_valid = 1'b0;
    logic [TW-1:0]         ins_src_l = '0, ins_src_r = '0, ins_dst = '0;
    logic                  ins_rdy_l = 1'b0, ins_rdy_r = 1'b0;
    logic                  ins_ready;
    logic [LANES-1:0]      bc_valid = '0;
    logic [LANES*TW-1:0]   bc_tag = '0;
    logic [UNITS-1:0]      gnt_valid;
    logic [UNITS*XW-1:0]   gnt_idx;
    logic [UNITS*TW-1:0]   gnt_dst;

    issue_window #(.WINSIZE(WIN), .IW(LANES), .NFU(UNITS), .TAG_W(TW)) i_issue_window (
        .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_src_l(ins_src_l),
        .ins_src_r(ins_src_r), .ins_dst(ins_dst), .ins_rdy_l(ins_rdy_l),
        .ins_rdy_r(ins_rdy_r), .ins_ready(ins_ready), .bc_valid(bc_valid),
        .bc_tag(bc_tag), .gnt_valid(gnt_valid), .gnt_idx(gnt_idx), .gnt_dst(gnt_dst)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Reference model state.
    bit m_occ [WIN];
    bit m_rl  [WIN];
    bit m_rr  [WIN];
    int m_tl  [WIN];
    int m_tr  [WIN];
    int m_dst [WIN];
    bit e_gv  [UNITS];
    int e_gi  [UNITS];

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic bit lane_hit(int tag);
        for (int k = 0; k < LANES; k++)
            if (bc_valid[k] && int'(bc_tag[k*TW +: TW]) == tag) return 1'b1;
        return 1'b0;
    endfunction

    // Expected grants: lowest requesting slots in index order.
    task automatic model_grants();
        int f = 0;
        for (int u = 0; u < UNITS; u++) begin e_gv[u] = 0; e_gi[u] = 0; end
        for (int i = 0; i < WIN; i++) begin
            if (f < UNITS && m_occ[i] && m_rl[i] && m_rr[i]) begin
                e_gv[f] = 1; e_gi[f] = i; f++;
            end
        end
    endtask

    // Advance the model by one edge with the inputs currently driven.
    task automatic model_update();
        bit gr [WIN];
        int fs = -1;
        for (int i = 0; i < WIN; i++) gr[i] = 0;
        for (int u = 0; u < UNITS; u++) if (e_gv[u]) gr[e_gi[u]] = 1;
        for (int i = WIN-1; i >= 0; i--) if (!m_occ[i]) fs = i;
        for (int i = 0; i < WIN; i++) begin
            if (gr[i]) m_occ[i] = 0;
            else if (m_occ[i]) begin
                if (lane_hit(m_tl[i])) m_rl[i] = 1;
                if (lane_hit(m_tr[i])) m_rr[i] = 1;
            end
        end
        if (ins_valid && fs >= 0) begin
            m_occ[fs] = 1;
            m_tl[fs]  = int'(ins_src_l);
            m_tr[fs]  = int'(ins_src_r);
            m_dst[fs] = int'(ins_dst);
            m_rl[fs]  = ins_rdy_l | lane_hit(int'(ins_src_l));
            m_rr[fs]  = ins_rdy_r | lane_hit(int'(ins_src_r));
        end
    endtask

    // One cycle: compare against the model, take the edge, update the model.
    task automatic step();
        bit any_free = 0;
        #1;
        model_grants();
        for (int i = 0; i < WIN; i++) if (!m_occ[i]) any_free = 1;
        chk("R2", "ins_ready vs model", int'(ins_ready), int'(any_free));
        for (int u = 0; u < UNITS; u++) begin
            chk("R6", $sformatf("unit %0d grant valid", u), int'(gnt_valid[u]), int'(e_gv[u]));
            if (e_gv[u] && gnt_valid[u]) begin
                chk("R6", $sformatf("unit %0d grant index", u), int'(gnt_idx[u*XW +: XW]), e_gi[u]);
                chk("R6", $sformatf("unit %0d grant tag", u), int'(gnt_dst[u*TW +: TW]), m_dst[e_gi[u]]);
            end
        end
        @(posedge clk);
        model_update();
        @(negedge clk);
    endtask

    task automatic idle();
        ins_valid = 0; bc_valid = '0;
    endtask

    task automatic put(int l, int r, int d, bit rl, bit rr);
        ins_valid = 1; ins_src_l = TW'(l); ins_src_r = TW'(r); ins_dst = TW'(d);
        ins_rdy_l = rl; ins_rdy_r = rr;
    endtask

    task automatic lane(int k, bit v, int tag);
        bc_valid[k] = v; bc_tag[k*TW +: TW] = TW'(tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < WIN; i++) begin
            m_occ[i] = 0; m_rl[i] = 0; m_rr[i] = 0; m_tl[i] = 0; m_tr[i] = 0; m_dst[i] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        #1;
        // R1 reset state
        chk("R1", "ins_ready after reset", int'(ins_ready), 1);
        chk("R1", "gnt_valid after reset", int'(gnt_valid), 0);

        // Two waiting slots, woken one operand at a time.
        put(10, 11, 20, 0, 0); step();
        put(12, 13, 21, 1, 0); step();
        idle(); #1;
        // R5 half-ready slots do not request
        chk("R5", "no grant with operands missing", int'(gnt_valid), 0);
        lane(0, 1, 10); lane(1, 0, 13); step();
        idle(); #1;
        // R4 disabled lane ignored, single operand not enough
        chk("R4", "no grant after partial wakeup", int'(gnt_valid), 0);
        lane(0, 1, 13); lane(1, 1, 11); step();
        idle(); #1;
        chk("R4", "both slots woken", int'(gnt_valid), 3);
        chk("R4", "unit0 index", int'(gnt_idx[0 +: XW]), 0);
        chk("R4", "unit0 tag", int'(gnt_dst[0 +: TW]), 20);
        chk("R4", "unit1 index", int'(gnt_idx[XW +: XW]), 1);
        chk("R4", "unit1 tag", int'(gnt_dst[TW +: TW]), 21);
        step();
        #1;
        // R7 granted slots gone after the edge
        chk("R7", "no regrant after issue", int'(gnt_valid), 0);

        // Insert-time match and back-to-back wakeup.
        put(40, 33, 41, 0, 1); step();
        put(30, 31, 40, 0, 1); lane(0, 1, 30); step();
        idle(); #1;
        // R3 insert-time broadcast match
        chk("R3", "inserted slot granted next cycle", int'(gnt_valid), 1);
        chk("R3", "inserted slot index", int'(gnt_idx[0 +: XW]), 1);
        chk("R3", "inserted slot tag", int'(gnt_dst[0 +: TW]), 40);
        lane(0, 1, 40); step();
        idle(); #1;
        // R8 dependent granted right after the producer
        chk("R8", "dependent granted", int'(gnt_valid[0]), 1);
        chk("R8", "dependent index", int'(gnt_idx[0 +: XW]), 0);
        chk("R8", "dependent tag", int'(gnt_dst[0 +: TW]), 41);
        chk("R7", "producer not granted again", int'(gnt_valid[1]), 0);
        step();

        // Fill the window, try an insert when full, then drain.
        for (int k = 0; k < WIN; k++) begin
            put(50, 51, 60 + k, 0, 0); step();
        end
        idle(); #1;
        chk("R2", "full window not ready", int'(ins_ready), 0);
        put(1, 2, 99, 1, 1); step();
        idle(); #1;
        chk("R2", "insert when full ignored", int'(gnt_valid), 0);
        lane(0, 1, 50); lane(1, 1, 51); step();
        idle(); #1;
        chk("R6", "drain unit0 index", int'(gnt_idx[0 +: XW]), 0);
        chk("R6", "drain unit1 index", int'(gnt_idx[XW +: XW]), 1);
        step();
        #1;
        chk("R6", "drain next unit0 index", int'(gnt_idx[0 +: XW]), 2);
        chk("R6", "drain next unit1 tag", int'(gnt_dst[TW +: TW]), 63);
        repeat (4) step();
        #1;
        chk("R2", "ready after drain", int'(ins_ready), 1);

        // Random phase with a small tag space.
        for (int c = 0; c < 400; c++) begin
            model_grants();
            ins_valid = ($urandom_range(0, 3) != 0);
            ins_src_l = TW'($urandom_range(0, 15));
            ins_src_r = TW'($urandom_range(0, 15));
            ins_dst   = TW'($urandom_range(0, 15));
            ins_rdy_l = ($urandom_range(0, 1) == 1);
            ins_rdy_r = ($urandom_range(0, 1) == 1);
            if (e_gv[0] && $urandom_range(0, 3) != 0) lane(0, 1, m_dst[e_gi[0]]);
            else lane(0, ($urandom_range(0, 1) == 1), int'($urandom_range(0, 15)));
            lane(1, ($urandom_range(0, 1) == 1), int'($urandom_range(0, 15)));
            step();
        end
        idle();
        repeat (8) step();
        finish_run();
    end

endmodule